// File: doc/BRIEF.md
# Sync Round-Trip Latency Monitor

This block measures how many clock cycles a synchronisation marker takes to travel out and come back. A local request input marks the moment the marker leaves. The marker returns on the top bit (bit 15) of a 16-bit sample word that arrives every clock. That same bit also carries a preamplifier inhibit flag, combined by OR. The other bits carry sample data and are of no interest here. The block tells a returned marker apart from an inhibit by how long the bit stays high. A short high run is a marker, and a run longer than a programmable width limit is an inhibit.

The first latency measured after reset becomes the reference. Calibration can be requested again at any time. Every later measurement is compared with the reference. A difference of even one cycle sets a sticky mismatch flag, which points to a lost or extra clock somewhere in the loop. A measurement is dropped without error in two cases: the marker cannot be seen because the shared bit is already high, or the high run turns out to be an inhibit. If nothing returns within a programmable number of cycles, a one-cycle timeout flag is raised.

Top module: `sync_rtt_monitor`

## Requirements
- R1: While reset is held and after it is released, `lat_valid`, `timeout_flag` and `mismatch_err` are 0 and `lat_out` is 0.
- R2: Suppose `sync_issue` is sampled high at edge k from idle, and bit 15 of `rx_word` is first sampled high (after being low) at edge k+L. Then the reported latency is L. Bits 14..0 of `rx_word` have no effect on any output.
- R3: A high run on bit 15 that lasts at most `width_lim` cycles is a marker. It is reported on the edge that samples bit 15 low again: `lat_valid` is high for exactly one cycle and `lat_out` holds L.
- R4: A high run that reaches `width_lim`+1 cycles is an inhibit. It produces no `lat_valid`, no timeout and no change of `mismatch_err`.
- R5: The first reported latency after reset is stored as the reference. One cycle after any later report whose latency differs from the reference, `mismatch_err` goes high and stays high until calibration.
- R6: A cycle with `calibrate` high clears `mismatch_err` on the next edge. The next reported latency then replaces the reference and raises no mismatch.
- R7: Bit 15 may already be high (with no rising edge) while a return is awaited. In that case the measurement is abandoned without `lat_valid`, timeout or mismatch.
- R8: A rising edge seen at L equal to `tmo_lim` is still measured. If no rising edge is seen by L = `tmo_lim`, `timeout_flag` pulses for one cycle and the block returns to idle.
- R9: `sync_issue` is ignored while a measurement is pending, and does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_issue | input | 1 | Marker sent out in this cycle |
| calibrate | input | 1 | Clear mismatch and re-take the reference on the next report |
| width_lim | input | 4 | Longest high run, in cycles, still classed as a marker (at least 1) |
| tmo_lim | input | 8 | Largest latency accepted before timing out |
| rx_word | input | 16 | Returned sample word; bit 15 is marker OR inhibit |
| lat_out | output | 8 | Latency of the last captured rising edge |
| lat_valid | output | 1 | One-cycle strobe: `lat_out` is a classified marker latency |
| mismatch_err | output | 1 | Sticky: a latency differed from the reference |
| timeout_flag | output | 1 | One-cycle pulse: no return within `tmo_lim` |

## Verification
The assertions assume that `width_lim` and `tmo_lim` stay constant while a measurement is pending and that `width_lim` is at least 1. The stimulus changes the limits only while the block is idle. On that basis the properties require that reports are bounded by the timeout and that a mismatch follows a report by one cycle. The stimulus places marker and inhibit runs at chosen offsets from each request, with nonzero patterns on the low data bits. It covers runs exactly at and one past the width limit, returns exactly at and one past the timeout, and requests sent while the shared bit is already held high.

// File: rtl/sync_rtt_pkg.sv
package sync_rtt_pkg;

    localparam int RTT_DATA_W = 16;
    localparam int RTT_CNT_W  = 8;
    localparam int RTT_RUN_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } rtt_state_e;

    // Per-cycle view of the shared flag line
    typedef struct packed {
        logic high;
        logic rise;
    } line_ev_t;

    // A high run is still a marker while its length has not reached the limit
    function automatic logic run_can_grow(input logic [RTT_RUN_W-1:0] run_len,
                                          input logic [RTT_RUN_W-1:0] lim);
        return run_len < lim;
    endfunction

endpackage

// File: rtl/rtt_line_tracker.sv
module rtt_line_tracker
    import sync_rtt_pkg::*;
#(
    parameter int DATA_W   = RTT_DATA_W,
    parameter int FLAG_BIT = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] word_in,
    output line_ev_t          ev
);
    logic flag_now;
    logic flag_prev;
    logic unused_data;

    assign flag_now    = word_in[FLAG_BIT];
    assign unused_data = ^word_in[FLAG_BIT-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_prev <= 1'b0;
        end else begin
            flag_prev <= flag_now;
        end
    end

    always_comb begin
        ev.high = flag_now;
        ev.rise = flag_now & ~flag_prev;
    end

endmodule

// File: rtl/rtt_measure_fsm.sv
module rtt_measure_fsm
    import sync_rtt_pkg::*;
#(
    parameter int CNT_W = RTT_CNT_W,
    parameter int RUN_W = RTT_RUN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    input  line_ev_t         ev,
    input  logic [RUN_W-1:0] run_lim,
    input  logic [CNT_W-1:0] wait_lim,
    output logic [CNT_W-1:0] cap_lat,
    output logic             meas_ok,
    output logic             wait_expired
);
    rtt_state_e       state;
    logic [CNT_W-1:0] elapsed;
    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            elapsed      <= '0;
            run_len      <= '0;
            cap_lat      <= '0;
            meas_ok      <= 1'b0;
            wait_expired <= 1'b0;
        end else begin
            meas_ok      <= 1'b0;
            wait_expired <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (issue) begin
                        elapsed <= CNT_W'(1);
                        state   <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (ev.rise) begin
                        cap_lat <= elapsed;
                        run_len <= RUN_W'(1);
                        state   <= ST_RUN;
                    end else if (ev.high) begin
                        // line held by inhibit: marker hidden, drop quietly
                        state <= ST_IDLE;
                    end else if (elapsed >= wait_lim) begin
                        wait_expired <= 1'b1;
                        state        <= ST_IDLE;
                    end else begin
                        elapsed <= elapsed + CNT_W'(1);
                    end
                end
                ST_RUN: begin
                    if (!ev.high) begin
                        meas_ok <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (!run_can_grow(run_len, run_lim)) begin
                        // run too long: inhibit, no report
                        state <= ST_IDLE;
                    end else begin
                        run_len <= run_len + RUN_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rtt_reference.sv
module rtt_reference
    import sync_rtt_pkg::*;
#(
    parameter int CNT_W = RTT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             recal,
    input  logic             meas_ok,
    input  logic [CNT_W-1:0] meas_lat,
    output logic             drift
);
    logic [CNT_W-1:0] base_lat;
    logic             base_set;
    logic             retake;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_lat <= '0;
            base_set <= 1'b0;
            retake   <= 1'b0;
            drift    <= 1'b0;
        end else if (recal) begin
            drift  <= 1'b0;
            retake <= 1'b1;
        end else if (meas_ok) begin
            if (!base_set || retake) begin
                base_lat <= meas_lat;
                base_set <= 1'b1;
                retake   <= 1'b0;
            end else if (meas_lat != base_lat) begin
                drift <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sync_rtt_monitor.sv
module sync_rtt_monitor
    import sync_rtt_pkg::*;
#(
    parameter int DATA_W = RTT_DATA_W,
    parameter int CNT_W  = RTT_CNT_W,
    parameter int RUN_W  = RTT_RUN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_issue,
    input  logic              calibrate,
    input  logic [RUN_W-1:0]  width_lim,
    input  logic [CNT_W-1:0]  tmo_lim,
    input  logic [DATA_W-1:0] rx_word,
    output logic [CNT_W-1:0]  lat_out,
    output logic              lat_valid,
    output logic              mismatch_err,
    output logic              timeout_flag
);
    localparam int FLAG_BIT = DATA_W - 1;

    line_ev_t         line_ev;
    logic [CNT_W-1:0] cap_lat;
    logic             meas_ok;
    logic             wait_expired;
    logic             drift;

    rtt_line_tracker #(
        .DATA_W   (DATA_W),
        .FLAG_BIT (FLAG_BIT)
    ) u_line (
        .clk     (clk),
        .rst     (rst),
        .word_in (rx_word),
        .ev      (line_ev)
    );

    rtt_measure_fsm #(
        .CNT_W (CNT_W),
        .RUN_W (RUN_W)
    ) u_meas (
        .clk          (clk),
        .rst          (rst),
        .issue        (sync_issue),
        .ev           (line_ev),
        .run_lim      (width_lim),
        .wait_lim     (tmo_lim),
        .cap_lat      (cap_lat),
        .meas_ok      (meas_ok),
        .wait_expired (wait_expired)
    );

    rtt_reference #(
        .CNT_W (CNT_W)
    ) u_ref (
        .clk      (clk),
        .rst      (rst),
        .recal    (calibrate),
        .meas_ok  (meas_ok),
        .meas_lat (cap_lat),
        .drift    (drift)
    );

    assign lat_out      = cap_lat;
    assign lat_valid    = meas_ok;
    assign mismatch_err = drift;
    assign timeout_flag = wait_expired;

endmodule

// File: rtl/sync_rtt_monitor_checker.sv
module sync_rtt_monitor_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             calibrate,
    input logic [CNT_W-1:0] tmo_lim,
    input logic [CNT_W-1:0] lat_out,
    input logic             lat_valid,
    input logic             mismatch_err,
    input logic             timeout_flag
);
    p_valid_single_r3: assert property (@(posedge clk) disable iff (rst)
        lat_valid |=> !lat_valid);

    p_timeout_single_r8: assert property (@(posedge clk) disable iff (rst)
        timeout_flag |=> !timeout_flag);

    p_valid_vs_timeout_r8: assert property (@(posedge clk) disable iff (rst)
        !(lat_valid && timeout_flag));

    p_lat_in_window_r8: assert property (@(posedge clk) disable iff (rst)
        lat_valid |-> (lat_out != '0 && lat_out <= tmo_lim));

    p_mismatch_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (mismatch_err && !calibrate) |=> mismatch_err);

    p_mismatch_after_report_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(mismatch_err) |-> $past(lat_valid));

    p_cal_clears_r6: assert property (@(posedge clk) disable iff (rst)
        calibrate |=> !mismatch_err);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!lat_valid && !timeout_flag && !mismatch_err));

endmodule

bind sync_rtt_monitor sync_rtt_monitor_checker #(
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .calibrate    (calibrate),
    .tmo_lim      (tmo_lim),
    .lat_out      (lat_out),
    .lat_valid    (lat_valid),
    .mismatch_err (mismatch_err),
    .timeout_flag (timeout_flag)
);

// File: tb/sync_rtt_monitor_test.sv
`timescale 1ns/1ps
module sync_rtt_monitor_test;

    localparam int TMO = 40;
    localparam int NV  = 9;

    // vector table: calibrate, latency (0 = no return), run width,
    // expected reports, expected sticky mismatch, expected timeouts
    localparam int V_CAL [NV] = '{0, 0, 0, 0, 1, 0, 0, 0, 0};
    localparam int V_LAT [NV] = '{12, 12, 13, 12, 14, 14, 14, 0, 13};
    localparam int V_WID [NV] = '{1, 2, 1, 1, 2, 1, 6, 0, 1};
    localparam int V_NV  [NV] = '{1, 1, 1, 1, 1, 1, 0, 0, 1};
    localparam int V_MM  [NV] = '{0, 0, 1, 1, 0, 0, 0, 0, 1};
    localparam int V_TO  [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_issue = 1'b0;
    logic        calibrate = 1'b0;
    logic [3:0]  width_lim = 4'd2;
    logic [7:0]  tmo_lim = 8'(TMO);
    logic [15:0] rx_word = '0;
    logic [7:0]  lat_out;
    logic        lat_valid;
    logic        mismatch_err;
    logic        timeout_flag;

    int n_checks = 0;
    int n_fails  = 0;
    int n_valid  = 0;
    int n_to     = 0;
    int last_lat = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    sync_rtt_monitor uut (
        .clk          (clk),
        .rst          (rst),
        .sync_issue   (sync_issue),
        .calibrate    (calibrate),
        .width_lim    (width_lim),
        .tmo_lim      (tmo_lim),
        .rx_word      (rx_word),
        .lat_out      (lat_out),
        .lat_valid    (lat_valid),
        .mismatch_err (mismatch_err),
        .timeout_flag (timeout_flag)
    );

    always @(negedge clk) begin
        if (!rst && lat_valid) begin
            n_valid  <= n_valid + 1;
            last_lat <= int'(lat_out);
        end
        if (!rst && timeout_flag) n_to <= n_to + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // request at edge k, bit 15 high from edge k+lat for wid edges
    task automatic measure(input int cal, input int lat, input int wid,
                           input logic [14:0] low);
        rx_word[14:0] = low;
        @(negedge clk);
        sync_issue = 1'b1;
        calibrate  = (cal != 0);
        @(negedge clk);
        sync_issue = 1'b0;
        calibrate  = 1'b0;
        rx_word[14:0] = ~low;
        if (lat > 0) begin
            repeat (lat - 1) @(negedge clk);
            rx_word[15] = 1'b1;
            repeat (wid) @(negedge clk);
            rx_word[15] = 1'b0;
            repeat (8) @(negedge clk);
        end else begin
            repeat (TMO + 10) @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int v0;
        int t0;
        rx_word = 16'h8000;
        repeat (4) @(negedge clk);
        // R1: outputs quiet during and after reset
        chk("R1 lat_valid", int'(lat_valid), 0);
        chk("R1 timeout_flag", int'(timeout_flag), 0);
        rst = 1'b0;
        rx_word = '0;
        repeat (3) @(negedge clk);
        chk("R1 mismatch_err", int'(mismatch_err), 0);
        chk("R1 lat_out", int'(lat_out), 0);
        chk("R1 no spurious report", n_valid, 0);

        for (int i = 0; i < NV; i++) begin
            v0 = n_valid;
            t0 = n_to;
            measure(V_CAL[i], V_LAT[i], V_WID[i], 15'(16'h4000 | (i * 4661)));
            chk($sformatf("R3/R4 vector %0d report count", i), n_valid - v0, V_NV[i]);
            if (V_NV[i] != 0)
                chk($sformatf("R2 vector %0d latency", i), last_lat, V_LAT[i]);
            chk($sformatf("R5/R6 vector %0d mismatch", i), int'(mismatch_err), V_MM[i]);
            chk($sformatf("R8 vector %0d timeouts", i), n_to - t0, V_TO[i]);
        end

        // R7: line already held high when the request goes out
        v0 = n_valid;
        t0 = n_to;
        @(negedge clk);
        rx_word[15] = 1'b1;
        repeat (3) @(negedge clk);
        sync_issue = 1'b1;
        @(negedge clk);
        sync_issue = 1'b0;
        repeat (20) @(negedge clk);
        rx_word[15] = 1'b0;
        repeat (TMO + 5) @(negedge clk);
        chk("R7 masked report count", n_valid - v0, 0);
        chk("R7 masked timeouts", n_to - t0, 0);
        chk("R7 mismatch unchanged", int'(mismatch_err), 1);

        // R9: second request while pending does not restart the count
        v0 = n_valid;
        @(negedge clk);
        sync_issue = 1'b1;
        @(negedge clk);
        sync_issue = 1'b0;
        repeat (4) @(negedge clk);
        sync_issue = 1'b1;
        @(negedge clk);
        sync_issue = 1'b0;
        repeat (6) @(negedge clk);
        rx_word[15] = 1'b1;
        @(negedge clk);
        rx_word[15] = 1'b0;
        repeat (8) @(negedge clk);
        chk("R9 one report", n_valid - v0, 1);
        chk("R9 latency from first request", last_lat, 12);

        // R6: recalibrate to 14, then equal latency gives no mismatch
        measure(1, 14, 1, 15'h1234);
        chk("R6 cleared after recalibration", int'(mismatch_err), 0);

        // R3/R4: width limit raised to 4, runs of 4 and 5
        width_lim = 4'd4;
        v0 = n_valid;
        measure(0, 14, 4, 15'h7FFF);
        chk("R3 run at limit reported", n_valid - v0, 1);
        chk("R3 run at limit latency", last_lat, 14);
        v0 = n_valid;
        measure(0, 14, 5, 15'h0001);
        chk("R4 run past limit dropped", n_valid - v0, 0);
        chk("R4 no mismatch from inhibit", int'(mismatch_err), 0);
        width_lim = 4'd2;

        // R8: return exactly at the limit is measured, one later times out
        v0 = n_valid;
        t0 = n_to;
        measure(0, TMO, 1, 15'h2AAA);
        chk("R8 return at limit reported", n_valid - v0, 1);
        chk("R8 return at limit latency", last_lat, TMO);
        chk("R8 return at limit no timeout", n_to - t0, 0);
        chk("R5 drift flagged", int'(mismatch_err), 1);
        v0 = n_valid;
        t0 = n_to;
        measure(0, TMO + 1, 1, 15'h5555);
        chk("R8 late return times out", n_to - t0, 1);
        chk("R8 late return not reported", n_valid - v0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule